// File: doc/BRIEF.md
# Integrating Vertical Sync Separator

This block recovers the field (vertical) sync from a digitised composite sync stream. An up/down counter acts as an integrator. On every cycle where the sample enable is high it steps up if the selected sync bit is high and steps down if it is low. The counter stops at zero and at a programmable ceiling, so it never wraps.

Short pulses cannot lift the count far before the long low stretch that follows pulls it back to zero. This applies to line sync and to equalizing pulses. The wide pulses of the field interval are high for most of each half line, so they raise the count a little further with every pulse. Once the count reaches an upper threshold, vertical sync is asserted. It is released only after the count falls below a lower threshold, and this hysteresis keeps isolated noise samples from chopping the output.

A select input chooses whether the main or the auxiliary sync input feeds the integrator. The output comes as a registered level and as a one-cycle pulse that marks each rising edge of that level.

Top module: `vsync_integrator`

## Requirements
- R1: On a clock with `sample_en` high and the selected sync high, `integ_level` increases by one in the next cycle; with `sample_en` low, `integ_level` does not change.
- R2: On a clock with `sample_en` high and the selected sync low, `integ_level` decreases by one in the next cycle.
- R3: `integ_level` saturates. A low sample at zero leaves it at zero, and a high sample at or above `cnt_max` sets it to `cnt_max`.
- R4: `src_sel` = 0 routes `csync_main` to the integrator and `src_sel` = 1 routes `csync_aux`. The input that is not selected has no effect on `integ_level`.
- R5: `vsync` becomes 1 one clock after `integ_level` is at least `thr_hi`. It becomes 0 one clock after `integ_level` is below `thr_lo`, and it holds its value while `integ_level` lies between the two thresholds.
- R6: `vsync_pulse` is high for exactly one clock, in the same cycle in which `vsync` rises, and is low at all other times.
- R7: A train of line-rate pulses (high for a small fraction of the line) never asserts `vsync`. A train of broad pulses (high for most of each half line) does assert it.
- R8: While `rst_n` is low, `integ_level`, `vsync` and `vsync_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Integrator step enable |
| src_sel | input | 1 | 0 selects main sync, 1 selects auxiliary sync |
| csync_main | input | 1 | Main composite sync bit |
| csync_aux | input | 1 | Auxiliary composite sync bit |
| cnt_max | input | CNT_W | Integrator ceiling |
| thr_hi | input | CNT_W | Assert threshold |
| thr_lo | input | CNT_W | Release threshold |
| integ_level | output | CNT_W | Integrator count |
| vsync | output | 1 | Vertical sync level |
| vsync_pulse | output | 1 | One-cycle pulse on the rising edge of vsync |

## Verification
The bench drives the integrator into its ceiling and floor. A design that wraps there would show a jump to 0 or to all ones instead of a held value. The bench walks the count down to exactly `thr_lo` and then one step below it. An off-by-one compare would release early or late, and a design without hysteresis would drop `vsync` as soon as the count fell under `thr_hi`. The bench also toggles the input that is not selected, which shows whether the source select is swapped or ORed. It checks that line-rate pulses never reach the threshold, which a design with no down-count would fail.

// File: rtl/vsync_integrator.sv
module vsync_integrator #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             src_sel,
  input  logic             csync_main,
  input  logic             csync_aux,
  input  logic [CNT_W-1:0] cnt_max,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  output logic [CNT_W-1:0] integ_level,
  output logic             vsync,
  output logic             vsync_pulse
);

  logic             sync_in;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             rise, fall;

  assign sync_in = src_sel ? csync_aux : csync_main;

  always_comb begin
    cnt_next = cnt;
    if (sample_en) begin
      if (sync_in)
        cnt_next = (cnt >= cnt_max) ? cnt_max : cnt + 1'b1;
      else if (cnt != '0)
        cnt_next = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;

  assign rise = !vsync && (cnt >= thr_hi);
  assign fall =  vsync && (cnt <  thr_lo);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vsync       <= 1'b0;
      vsync_pulse <= 1'b0;
    end else begin
      vsync_pulse <= rise;
      if (rise)      vsync <= 1'b1;
      else if (fall) vsync <= 1'b0;
    end

  assign integ_level = cnt;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(cnt)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && sync_in && cnt < cnt_max |=> cnt == $past(cnt) + 1'b1); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !sync_in && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !sync_in && cnt == '0 |=> cnt == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && sync_in && cnt >= cnt_max |=> cnt == $past(cnt_max)); // R3
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vsync && cnt >= thr_lo |=> vsync); // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_pulse |=> !vsync_pulse); // R6
  AST_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_pulse |-> vsync && !$past(vsync)); // R6

endmodule

// File: tb/test_vsync_integrator.sv
module test_vsync_integrator;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0, src_sel = 1'b0, csync_main = 1'b0, csync_aux = 1'b0;
  logic [W-1:0] cnt_max = 8'd40, thr_hi = 8'd30, thr_lo = 8'd10;
  logic [W-1:0] integ_level;
  logic vsync, vsync_pulse;
  int n_tests = 0, n_fail = 0;
  int peak;

  always #5 clk = ~clk;

  vsync_integrator #(.CNT_W(W)) i_vsync_integrator (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .src_sel(src_sel),
    .csync_main(csync_main), .csync_aux(csync_aux), .cnt_max(cnt_max),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .integ_level(integ_level),
    .vsync(vsync), .vsync_pulse(vsync_pulse));

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one sample, then two idle clocks: count and vsync both settled on return
  task automatic step(input logic m, input logic a);
    @(negedge clk);
    csync_main = m; csync_aux = a; sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic steps(input int n, input logic m);
    for (int i = 0; i < n; i++) step(m, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 count", integ_level, 0);
    check("R8 vsync", vsync, 0);
    check("R8 pulse", vsync_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_updown();
    do_reset();
    steps(5, 1'b1);
    check("R1 up", integ_level, 5);
    @(negedge clk); csync_main = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 hold without enable", integ_level, 5);
    steps(2, 1'b0);
    check("R2 down", integ_level, 3);
  endtask

  task automatic t_saturate();
    do_reset();
    steps(3, 1'b0);
    check("R3 floor", integ_level, 0);
    steps(45, 1'b1);
    check("R3 ceiling", integ_level, 40);
    cnt_max = 8'd35;
    step(1'b1, 1'b0);
    check("R3 ceiling lowered", integ_level, 35);
    cnt_max = 8'd40;
  endtask

  task automatic t_source();
    do_reset();
    src_sel = 1'b0;
    step(1'b0, 1'b1);
    check("R4 aux ignored", integ_level, 0);
    step(1'b1, 1'b0);
    check("R4 main used", integ_level, 1);
    src_sel = 1'b1;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R4 aux used", integ_level, 3);
    step(1'b1, 1'b0);
    check("R4 main ignored", integ_level, 2);
    src_sel = 1'b0;
  endtask

  task automatic t_hyst();
    do_reset();
    steps(29, 1'b1);
    check("R5 below hi", vsync, 0);
    check("R6 no pulse", vsync_pulse, 0);
    step(1'b1, 1'b0);
    check("R5 at hi", vsync, 1);
    check("R6 pulse", vsync_pulse, 1);
    step(1'b1, 1'b0);
    check("R6 pulse single", vsync_pulse, 0);
    steps(21, 1'b0);
    check("R5 count at lo", integ_level, 10);
    check("R5 held at lo", vsync, 1);
    step(1'b0, 1'b0);
    check("R5 release", vsync, 0);
    check("R6 no pulse on fall", vsync_pulse, 0);
  endtask

  task automatic t_lines();
    do_reset();
    peak = 0;
    for (int l = 0; l < 6; l++) begin
      steps(5, 1'b1);
      if (integ_level > peak) peak = integ_level;
      steps(59, 1'b0);
    end
    for (int e = 0; e < 6; e++) begin
      steps(2, 1'b1);
      steps(30, 1'b0);
    end
    check("R7 line sync rejected", vsync, 0);
    check("R7 line peak", peak, 5);
    for (int b = 0; b < 3; b++) begin
      steps(27, 1'b1);
      steps(5, 1'b0);
    end
    check("R7 broad pulses detected", vsync, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_updown();
    t_saturate();
    t_source();
    t_hyst();
    t_lines();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule